// File: doc/BRIEF.md
# Master Clock Source Switch Controller

This block decides which oscillator drives the master clock of a small microcontroller clock unit. Software writes an 8-bit control word through a simple register port. The word holds a requested source code and separate run enables for the main oscillator, the sub oscillator and the PLL. Each enabled source waits out its own stabilisation interval, which a per-source counter models, before it is declared ready. The block moves the active master clock to the requested source only once that source is ready.

An 8-bit status word gives the active source code and one ready flag per oscillator. The active source is reported apart from the requested one, so software can poll until the switch has happened. The internal high-speed RC source needs no start-up and is always available. Undefined source codes fall back to it. The run enable of the oscillator that currently drives the master clock cannot be turned off. Both words are cleared only by the hardware reset input.

Top module: `clk_src_switch`

## Requirements
- R1: After hardware reset, the control word reads 0x00, the status word reads 0x00 and `act_sel` is 000 (high-speed RC).
- R2: Bits 2 and 0 of both words always read 0. Writing 1 to them stores nothing. Writes to the status address (addr=1) change nothing.
- R3: Control layout: bits 7:5 request code, bit 4 PLL enable, bit 3 sub enable, bit 1 main enable. Status layout: bits 7:5 active code, bit 4 PLL ready, bit 3 sub ready, bit 1 main ready. A ready bit reads 0 while its enable is 0 or while stabilising. It reads 1 exactly W clock edges after the edge that set the enable, where W is WAIT_PLL, WAIT_SUB or WAIT_MAIN.
- R4: A write that clears an enable bit clears the matching ready bit in the same cycle that the enable bit first reads 0.
- R5: Codes are 000 high-speed RC, 001 main oscillator, 010 PLL and 100 sub oscillator. While the requested source is not ready, the active code keeps its value. It takes the requested code on the first clock edge at which the requested ready bit is 1, so one cycle after that bit first reads 1.
- R6: Requesting code 000 switches the active code to 000 on the clock edge after the write.
- R7: Codes 011, 101, 110 and 111 read back unchanged in the control word, but act as requests for high-speed RC (active code 000).
- R8: A write that clears the enable of the oscillator that is the current active source leaves that enable bit at 1. Its ready bit stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 1 | 0 selects the control word, 1 the status word |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed word (combinational) |
| act_sel | output | 3 | Code of the source currently driving the master clock |

## Verification
Every cycle, the assertions check four things: reserved bits read as zero, no ready flag stands without its enable, the active code is always one of the four defined codes and always has its oscillator enabled, and a change of active source only ever lands on a source that was ready in the cycle before. The exact stabilisation interval of each source is shown only by the bench's scenarios. So are the one-cycle lag between ready and switch, the decode of every request code, the refused disable of the running oscillator and the full reserved-bit write sweep.

// File: rtl/clk_switch_pkg.sv
// Package: shared codes, register bit positions and decode helpers for the
// master clock source switch. Assumes three startable sources plus an RC
// source that is always running.
package clk_switch_pkg;

    localparam int REG_W    = 8;
    localparam int CODE_W   = 3;
    localparam int N_OSC    = 3;       // main, sub, PLL
    localparam int CODE_LSB = 5;

    // Oscillator index order inside enable/ready vectors
    localparam int OSC_MAIN = 0;
    localparam int OSC_SUB  = 1;
    localparam int OSC_PLL  = 2;

    // Bit position of each oscillator's enable/ready bit in the 8-bit words
    localparam int POS_MAIN = 1;
    localparam int POS_SUB  = 3;
    localparam int POS_PLL  = 4;

    typedef enum logic [CODE_W-1:0] {
        SRC_HSRC = 3'b000,
        SRC_MAIN = 3'b001,
        SRC_PLL  = 3'b010,
        SRC_SUB  = 3'b100
    } src_e;

    // Map a raw request code to a defined source; undefined codes mean RC.
    function automatic src_e decode_req(input logic [CODE_W-1:0] code);
        case (code)
            3'b001:  return SRC_MAIN;
            3'b010:  return SRC_PLL;
            3'b100:  return SRC_SUB;
            default: return SRC_HSRC;
        endcase
    endfunction

    // Bit position inside the 8-bit word for oscillator index i.
    function automatic int osc_pos(input int i);
        case (i)
            OSC_MAIN: return POS_MAIN;
            OSC_SUB:  return POS_SUB;
            default:  return POS_PLL;
        endcase
    endfunction

    // Source code owned by oscillator index i.
    function automatic src_e osc_code(input int i);
        case (i)
            OSC_MAIN: return SRC_MAIN;
            OSC_SUB:  return SRC_SUB;
            default:  return SRC_PLL;
        endcase
    endfunction

    // Ready state of a source given the oscillator ready vector.
    function automatic logic src_ready(input src_e s, input logic [N_OSC-1:0] rdy);
        case (s)
            SRC_MAIN: return rdy[OSC_MAIN];
            SRC_SUB:  return rdy[OSC_SUB];
            SRC_PLL:  return rdy[OSC_PLL];
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/osc_stab_timer.sv
// Module: osc_stab_timer
// Models one oscillator's start-up. Once the enable is seen high, the
// ready flag rises exactly WAIT clock edges after the edge that set the
// enable. The ready output is gated by the enable, so dropping the enable
// removes ready in the same cycle. Assumes WAIT >= 1.
module osc_stab_timer #(
    parameter int WAIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ready
);
    localparam int CNT_W = (WAIT > 1) ? $clog2(WAIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Count enabled cycles until the wait expires; restart when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Ready only while still enabled.
    assign ready = done_q & en;

endmodule

// File: rtl/clk_ctrl_regs.sv
// Module: clk_ctrl_regs
// Holds the writable control word: the raw request code and the three
// oscillator enables. Reserved bits are never stored. The enable of the
// oscillator that is the active source is forced to stay set. Writes go
// to address 0 only.
module clk_ctrl_regs
    import clk_switch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                addr,
    input  logic [REG_W-1:0]    wdata,
    input  src_e                act,
    output logic [CODE_W-1:0]   req_code,
    output logic [N_OSC-1:0]    en_vec
);
    logic [N_OSC-1:0] wr_en_bits;
    logic [N_OSC-1:0] keep_bits;

    // Extract the enable bits from write data and mark the protected one.
    generate
        for (genvar g = 0; g < N_OSC; g++) begin : g_bits
            assign wr_en_bits[g] = wdata[osc_pos(g)];
            assign keep_bits[g]  = (act == osc_code(g));
        end
    endgenerate

    // Capture control writes; cleared only by hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_code <= '0;
            en_vec   <= '0;
        end else if (wr_en && !addr) begin
            req_code <= wdata[CODE_LSB +: CODE_W];
            en_vec   <= wr_en_bits | keep_bits;
        end
    end

endmodule

// File: rtl/clk_sel_ctrl.sv
// Module: clk_sel_ctrl
// Tracks the source that actually drives the master clock. It takes the
// decoded request on the first edge at which the requested source is
// ready, and otherwise holds. Assumes the RC source is always ready.
module clk_sel_ctrl
    import clk_switch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   req_code,
    input  logic [N_OSC-1:0]    rdy_vec,
    output src_e                act
);
    src_e req;
    logic req_ok;

    // Decode the request and look up its readiness.
    always_comb begin
        req    = decode_req(req_code);
        req_ok = src_ready(req, rdy_vec);
    end

    // Move to the requested source once it is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= SRC_HSRC;
        end else if (req_ok && (req != act)) begin
            act <= req;
        end
    end

endmodule

// File: rtl/clk_src_switch.sv
// Module: clk_src_switch (top)
// Master clock source switch. The control word (addr 0) requests a source
// and enables the oscillators. The status word (addr 1) reports the active
// source and the ready flags. Reads are combinational. Stabilisation times
// are parameters, given in clock cycles.
module clk_src_switch
    import clk_switch_pkg::*;
#(
    parameter int WAIT_MAIN = 16,
    parameter int WAIT_SUB  = 16,
    parameter int WAIT_PLL  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [2:0]  act_sel
);
    localparam int WAITS [N_OSC] = '{WAIT_MAIN, WAIT_SUB, WAIT_PLL};

    logic [CODE_W-1:0] req_code;
    logic [N_OSC-1:0]  en_vec;
    logic [N_OSC-1:0]  rdy_vec;
    src_e              act;
    logic [REG_W-1:0]  ctrl_word;
    logic [REG_W-1:0]  stat_word;

    clk_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .act      (act),
        .req_code (req_code),
        .en_vec   (en_vec)
    );

    // One stabilisation timer per startable oscillator.
    generate
        for (genvar g = 0; g < N_OSC; g++) begin : g_osc
            osc_stab_timer #(.WAIT(WAITS[g])) u_timer (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en_vec[g]),
                .ready (rdy_vec[g])
            );
        end
    endgenerate

    clk_sel_ctrl u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_code (req_code),
        .rdy_vec  (rdy_vec),
        .act      (act)
    );

    // Assemble both words; reserved bits stay zero.
    always_comb begin
        ctrl_word = '0;
        stat_word = '0;
        ctrl_word[CODE_LSB +: CODE_W] = req_code;
        stat_word[CODE_LSB +: CODE_W] = act;
        for (int i = 0; i < N_OSC; i++) begin
            ctrl_word[osc_pos(i)] = en_vec[i];
            stat_word[osc_pos(i)] = rdy_vec[i];
        end
    end

    // Read mux by address.
    assign rdata   = addr ? stat_word : ctrl_word;
    assign act_sel = act;

endmodule

// File: rtl/clk_src_switch_chk.sv
// Module: clk_src_switch_chk
// Cycle-by-cycle properties of the clock source switch, bound to the top.
module clk_src_switch_chk
    import clk_switch_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        rdata,
    input logic [2:0]        act_sel,
    input logic [N_OSC-1:0]  en_vec,
    input logic [N_OSC-1:0]  rdy_vec
);
    logic seen;

    // Marks that at least one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    function automatic logic en_of(input logic [2:0] c, input logic [N_OSC-1:0] e);
        case (c)
            3'b001:  return e[OSC_MAIN];
            3'b100:  return e[OSC_SUB];
            3'b010:  return e[OSC_PLL];
            default: return 1'b1;
        endcase
    endfunction

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[2] == 1'b0) && (rdata[0] == 1'b0));

    // R4
    ready_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_vec & ~en_vec) == '0);

    // R7
    act_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_sel inside {3'b000, 3'b001, 3'b010, 3'b100});

    // R8
    active_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_of(act_sel, en_vec));

    // R5
    switch_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (act_sel != $past(act_sel)) |-> src_ready(src_e'(act_sel), $past(rdy_vec)));

    generate
        for (genvar g = 0; g < N_OSC; g++) begin : g_rise
            // R3
            ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
                $rose(rdy_vec[g]) |-> $past(en_vec[g]));
        end
    endgenerate

endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdata   (rdata),
    .act_sel (act_sel),
    .en_vec  (en_vec),
    .rdy_vec (rdy_vec)
);

// File: tb/clk_src_switch_test.sv
`timescale 1ns/1ps
module clk_src_switch_test;

    localparam int WM = 5;
    localparam int WS = 7;
    localparam int WP = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic       addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [2:0] act_sel;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    clk_src_switch #(.WAIT_MAIN(WM), .WAIT_SUB(WS), .WAIT_PLL(WP)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .act_sel(act_sel)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    function automatic logic [2:0] map_code(input logic [2:0] c);
        return (c == 3'b001 || c == 3'b010 || c == 3'b100) ? c : 3'b000;
    endfunction

    // Start one source, follow its ready bit and the switch, then return to RC.
    task automatic stab(input logic [2:0] code, input int pos, input int w);
        logic [7:0] v;
        logic [7:0] exp;
        wr(1'b0, 8'(code) << 5 | 8'(1) << pos);
        for (int n = 0; n <= w + 1; n++) begin
            exp = ((n >= w + 1) ? 8'(code) << 5 : 8'h00) | ((n >= w) ? 8'(1) << pos : 8'h00);
            rd(1'b1, v);
            chk((n < w + 1) ? "R3 ready timing" : "R5 switch after ready", v, exp);
            if (n <= w) @(negedge clk);
        end
        chk("R5 act_sel port", {5'b0, act_sel}, {5'b0, code});
        // R8: try to disable the running oscillator
        wr(1'b0, 8'(code) << 5);
        rd(1'b0, v);
        chk("R8 enable kept", v, 8'(code) << 5 | 8'(1) << pos);
        rd(1'b1, v);
        chk("R8 ready kept", v, 8'(code) << 5 | 8'(1) << pos);
        // R6: back to RC
        wr(1'b0, 8'(1) << pos);
        rd(1'b1, v);
        chk("R6 act before edge", v, 8'(code) << 5 | 8'(1) << pos);
        @(negedge clk);
        rd(1'b1, v);
        chk("R6 RC switch", v, 8'(1) << pos);
        // R4: disable now allowed, ready drops at once
        wr(1'b0, 8'h00);
        rd(1'b1, v);
        chk("R4 ready cleared", v, 8'h00);
        rd(1'b0, v);
        chk("R4 enable cleared", v, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk("R1 ctrl reset", v, 8'h00);
        rd(1'b1, v); chk("R1 status reset", v, 8'h00);
        chk("R1 act reset", {5'b0, act_sel}, 8'h00);
        rst_n = 1'b1;

        // R2: reserved-bit sweep over every write value
        for (int d = 0; d < 256; d++) begin
            wr(1'b0, 8'(d));
            rd(1'b0, v); chk("R2 ctrl readback", v, 8'(d) & 8'hFA);
            rd(1'b1, v); chk("R2 status idle", v, 8'h00);
            wr(1'b0, 8'h00);
        end
        wr(1'b1, 8'hFF);
        rd(1'b0, v); chk("R2 status write ignored ctrl", v, 8'h00);
        rd(1'b1, v); chk("R2 status write ignored status", v, 8'h00);

        // R5: request main without enabling it -> held
        wr(1'b0, 8'h20);
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            rd(1'b1, v); chk("R5 hold unready", v, 8'h00);
        end

        // R3/R5/R6/R8/R4 per source
        stab(3'b001, 1, WM);
        stab(3'b100, 3, WS);
        stab(3'b010, 4, WP);

        // R7: full code decode with every source ready
        wr(1'b0, 8'h1A);
        repeat (10) @(negedge clk);
        rd(1'b1, v); chk("R3 all ready", v, 8'h1A);
        for (int c = 0; c < 8; c++) begin
            wr(1'b0, 8'(c) << 5 | 8'h1A);
            rd(1'b0, v); chk("R7 raw code readback", v, 8'(c) << 5 | 8'h1A);
            rd(1'b1, v); chk("R5 no switch before edge", v, 8'h1A);
            @(negedge clk);
            rd(1'b1, v); chk("R7 decoded act", v, 8'(map_code(3'(c))) << 5 | 8'h1A);
            wr(1'b0, 8'h1A);
            @(negedge clk);
            rd(1'b1, v); chk("R6 back to RC", v, 8'h1A);
        end
        // R7: undefined code leaves a running PLL for RC
        for (int c = 3; c < 8; c++) begin
            if (c == 4) continue;
            wr(1'b0, 8'h5A);
            @(negedge clk);
            chk("R5 on PLL", {5'b0, act_sel}, 8'h02);
            wr(1'b0, 8'(c) << 5 | 8'h1A);
            @(negedge clk);
            chk("R7 undefined to RC", {5'b0, act_sel}, 8'h00);
        end

        // R1: hardware reset clears a live configuration
        wr(1'b0, 8'h3A);
        @(negedge clk);
        chk("R5 on main before reset", {5'b0, act_sel}, 8'h01);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, v); chk("R1 ctrl after reset", v, 8'h00);
        rd(1'b1, v); chk("R1 status after reset", v, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule